// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host side of a single conversion on a four-input serial successive-approximation converter. A one-cycle `start` request carries a channel number, an input-mode flag and a two-bit power mode. The sequencer packs these into an eight-bit command word, lowers the chip select and generates a serial clock from the system clock. It sends the command word on its serial data output and then collects a sixteen-bit conversion result from the converter's serial data line.

One transaction always takes 24 serial clocks. The first eight carry the command word. The converter answers during the following sixteen, which fill the second and third byte slots. At the end the sequencer raises chip select and returns the result with a one-cycle `done` strobe. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `sar_host_seq`

## Requirements
- R1: The command word is sent MSB first. Bit 7 is a constant 1 marker. Bits 6:4 hold the channel code. Bit 3 is sent as 0. Bits 1:0 repeat `pwr_mode`.
- R2: The channel code in bits 6:4 is 001 for channel 0, 101 for channel 1, 010 for channel 2 and 110 for channel 3. The same codes are used in both input modes.
- R3: Bit 2 of the command word is 1 when `single_end` is high and 0 when it is low.
- R4: Each transaction has exactly 24 rising `sclk` edges while `cs_n` is low. `sclk` stays high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks, and it is low whenever `cs_n` is high.
- R5: `cs_n` falls in the cycle after `start` is accepted, with `mosi` already showing the marker bit. The first rising `sclk` edge follows exactly one system clock later.
- R6: `mosi` changes only on falling `sclk` edges, or when a transaction is loaded. It is 0 from the 8th falling edge until the transaction ends.
- R7: `miso` is sampled at rising edges 9 through 24. The first sample becomes `result[15]` and the last becomes `result[0]`.
- R8: `done` is high for exactly one system clock. It rises in the same cycle that `cs_n` returns high and `sclk` is low. `result` keeps its value until the next `done`.
- R9: A `start` that arrives while a transaction is in progress is ignored. No extra transaction and no extra `done` follow from it.
- R10: A `start` given during the `done` cycle is accepted. `cs_n` falls again in the next cycle.
- R11: After reset, `cs_n` is 1, `sclk`, `mosi` and `done` are 0, and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a transaction; accepted only while idle |
| chan | input | 2 | Channel number 0..3 |
| single_end | input | 1 | 1 = single-ended input, 0 = differential pair |
| pwr_mode | input | 2 | Power mode field copied into the command word |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial command data to the converter |
| miso | input | 1 | Serial result data from the converter |
| done | output | 1 | One-cycle strobe when `result` is updated |
| result | output | RES_W | Last conversion result |

## Verification
The end of one transaction and the acceptance of the next can fall in the same system clock. The `done` strobe and a new `start` are both seen while the sequencer is back in its idle state. The bench provokes this by raising `start` in the very cycle it observes `done`. It then judges the result in three ways: `cs_n` must fall again one cycle later, the first result must match its own expected value, and the second transaction must carry its own command word and result without any rise or bit being lost. A converter model in the bench supplies distinct data for each transaction, so any mixing between the two would be caught.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  // Multiplexer code for a channel number (same for both input modes).
  function automatic logic [2:0] chan_code(input logic [1:0] ch);
    chan_code = {ch[0], ch[1], ~ch[1]};
  endfunction

  // Command word, MSB sent first.
  function automatic logic [CTRL_W-1:0] build_cmd(input logic [1:0] ch,
                                                  input logic       se,
                                                  input logic [1:0] pm);
    build_cmd = {1'b1, chan_code(ch), 1'b0, se, pm};
  endfunction

endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;

      assign tick = run && (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign bit_out = sr_q[W-1];

endmodule

// File: rtl/res_shifter.sv
module res_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = {q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
  import sar_seq_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int RES_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan,
  input  logic             single_end,
  input  logic [1:0]       pwr_mode,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             done,
  output logic [RES_W-1:0] result
);

  localparam int NUM_CLKS = CTRL_W + RES_W;
  localparam int RW       = $clog2(NUM_CLKS + 1);
  localparam logic [RW-1:0] LAST_RISE = RW'(NUM_CLKS);
  localparam logic [RW-1:0] CMD_RISES = RW'(CTRL_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e       state_q, state_d;
  logic             cs_n_q, cs_n_d;
  logic             sclk_q, sclk_d;
  logic [RW-1:0]    rise_q, rise_d;
  logic             done_q, done_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             tick, load_cmd, shift_cmd, capture;
  logic [RES_W-1:0] rx_word;

  sclk_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (state_q == ST_RUN),
    .tick  (tick)
  );

  cmd_shifter #(.W(CTRL_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load_cmd),
    .load_val (build_cmd(chan, single_end, pwr_mode)),
    .shift    (shift_cmd),
    .bit_out  (mosi)
  );

  res_shifter #(.W(RES_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n_s),
    .en    (capture),
    .din   (miso),
    .q     (rx_word)
  );

  // next state
  always_comb begin
    state_d   = state_q;
    cs_n_d    = cs_n_q;
    sclk_d    = sclk_q;
    rise_d    = rise_q;
    done_d    = 1'b0;
    res_d     = res_q;
    load_cmd  = 1'b0;
    shift_cmd = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_cmd = 1'b1;
          cs_n_d   = 1'b0;
          rise_d   = '0;
          state_d  = ST_LEAD;
        end
      end
      ST_LEAD: begin
        sclk_d  = 1'b1;
        rise_d  = RW'(1);
        state_d = ST_RUN;
      end
      ST_RUN: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d    = 1'b0;
            shift_cmd = 1'b1;
            if (rise_q == LAST_RISE) begin
              cs_n_d  = 1'b1;
              done_d  = 1'b1;
              res_d   = rx_word;
              state_d = ST_IDLE;
            end
          end else begin
            sclk_d  = 1'b1;
            rise_d  = rise_q + 1'b1;
            capture = (rise_q >= CMD_RISES);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      rise_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      rise_q  <= rise_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign cs_n   = cs_n_q;
  assign sclk   = sclk_q;
  assign done   = done_q;
  assign result = res_q;

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n_q |-> !sclk_q);

  // R4
  edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(cs_n_q) |-> (rise_q == LAST_RISE));

  // R5
  lead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cs_n_q) |-> (mosi && !sclk_q) ##1 (sclk_q && !cs_n_q));

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cs_n_q && !$fell(cs_n_q) && !$fell(sclk_q)) |-> $stable(mosi));

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |=> !done_q);

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_q |-> (cs_n_q && !sclk_q && $past(!cs_n_q)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_RUN && start) |=> (state_q != ST_LEAD));

endmodule

// File: tb/sar_host_seq_tb.sv
`timescale 1ns/1ps
module sar_host_seq_tb;

  localparam int RES_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       chan = 2'd0;
  logic             single_end = 1'b0;
  logic [1:0]       pwr_mode = 2'd0;
  logic             miso = 1'b0;
  logic             cs_n, sclk, mosi, done;
  logic [RES_W-1:0] result;

  always #5 clk = ~clk;

  sar_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
    .single_end(single_end), .pwr_mode(pwr_mode), .cs_n(cs_n),
    .sclk(sclk), .mosi(mosi), .miso(miso), .done(done), .result(result)
  );

  typedef struct packed {
    logic [7:0]       cmd;
    logic [RES_W-1:0] data;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected command word from R1..R3
  function automatic logic [7:0] exp_cmd(input logic [1:0] ch, input logic se,
                                          input logic [1:0] pm);
    logic [2:0] code;
    case (ch)
      2'd0:    code = 3'b001;
      2'd1:    code = 3'b101;
      2'd2:    code = 3'b010;
      default: code = 3'b110;
    endcase
    return {1'b1, code, 1'b0, se, pm};
  endfunction

  // converter model and monitor, both away from the active edge
  logic             prev_sclk = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;
  int               rises = 0, falls = 0, since = 0, lead = -1;
  logic [7:0]       cap_cmd = 8'h00;
  logic             mosi_bad = 1'b0;
  logic [RES_W-1:0] adc_val = '0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      rises = 0; falls = 0; since = 0; lead = -1;
      cap_cmd = 8'h00; mosi_bad = 1'b0;
      if (exp_q.size() > 0) adc_val = exp_q[0].data;
      else adc_val = '0;
    end else if (!cs_n) begin
      since++;
    end
    if (!cs_n && sclk && !prev_sclk) begin
      if (rises == 0) lead = since;
      if (rises < 8) cap_cmd = {cap_cmd[6:0], mosi};
      else if (mosi !== 1'b0) mosi_bad = 1'b1;
      rises++;
    end
    if (!cs_n && !sclk && prev_sclk) begin
      falls++;
      if (falls >= 8 && falls <= 23) miso = adc_val[23 - falls];
      else miso = 1'b0;
    end
    if (cs_n) miso = 1'b0;

    // monitor
    if (done && prev_done) chk("R8", "done longer than one cycle", 32'd1, 32'd0);
    if (done && !prev_done) begin
      if (exp_q.size() == 0) begin
        chk("R9", "done with no pending request", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk("R7", "result", 32'(result), 32'(it.data));
        chk("R1", "marker, bit3 and power field", 32'({cap_cmd[7], cap_cmd[3], cap_cmd[1:0]}),
            32'({it.cmd[7], it.cmd[3], it.cmd[1:0]}));
        chk("R2", "channel code", 32'(cap_cmd[6:4]), 32'(it.cmd[6:4]));
        chk("R3", "input mode bit", 32'(cap_cmd[2]), 32'(it.cmd[2]));
        chk("R4", "rising edge count", 32'(rises), 32'd24);
        chk("R5", "cycles from cs_n fall to first rise", 32'(lead), 32'd1);
        chk("R6", "mosi nonzero after command", 32'(mosi_bad), 32'd0);
        chk("R8", "cs_n high and sclk low at done", 32'({cs_n, sclk}), 32'b10);
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
    prev_done = done;
  end

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  task automatic issue(input logic [1:0] ch, input logic se, input logic [1:0] pm,
                       input logic [RES_W-1:0] data);
    item_t it;
    it.cmd  = exp_cmd(ch, se, pm);
    it.data = data;
    exp_q.push_back(it);
    chan = ch; single_end = se; pwr_mode = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_one(input logic [1:0] ch, input logic se, input logic [1:0] pm,
                         input logic [RES_W-1:0] data);
    issue(ch, se, pm, data);
    wait_done();
    repeat (5) @(negedge clk);
    chk("R8", "result held after done", 32'(result), 32'(data));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11
    chk("R11", "outputs after reset", 32'({cs_n, sclk, mosi, done}), 32'b1000);
    chk("R11", "result after reset", 32'(result), 32'd0);

    // R1 R2 R3 R7: every channel, both modes, varied data
    run_one(2'd0, 1'b1, 2'b00, 16'h0000);
    run_one(2'd1, 1'b1, 2'b01, 16'hFFFF);
    run_one(2'd2, 1'b1, 2'b10, 16'hA5C3);
    run_one(2'd3, 1'b1, 2'b11, 16'h8001);
    run_one(2'd0, 1'b0, 2'b11, 16'h1234);
    run_one(2'd3, 1'b0, 2'b01, 16'h7FFE);

    // R9: start during a transaction is ignored
    begin
      int lows;
      issue(2'd1, 1'b0, 2'b10, 16'h5A5A);
      repeat (30) @(negedge clk);
      chan = 2'd2; single_end = 1'b1; pwr_mode = 2'b00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      lows = 0;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        if (!cs_n) lows++;
      end
      chk("R9", "cs_n low after ignored start", 32'(lows), 32'd0);
      chk("R9", "pending requests", 32'(exp_q.size()), 32'd0);
    end

    // R10: start in the done cycle
    begin
      item_t it;
      issue(2'd2, 1'b0, 2'b01, 16'hC0DE);
      wait_done();
      it.cmd  = exp_cmd(2'd1, 1'b1, 2'b10);
      it.data = 16'h3C96;
      exp_q.push_back(it);
      chan = 2'd1; single_end = 1'b1; pwr_mode = 2'b10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "cs_n after start in done cycle", 32'(cs_n), 32'd0);
      wait_done();
      repeat (5) @(negedge clk);
      chk("R10", "second result", 32'(result), 32'h3C96);
      chk("R10", "pending requests", 32'(exp_q.size()), 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule